// File: doc/BRIEF.md
# FIFO Programmable Fill-Threshold Flags

This block drives the two threshold flags of one dual-clock FIFO. It takes the FIFO's write pointer from the write-clock domain and its read pointer from the read-clock domain. It carries each pointer into the other domain and produces two active-low flags:

- a near-empty flag, timed by the read clock;
- a near-full flag, timed by the write clock.

Each flag compares a fill level against its own offset register. Both offsets are set when the block leaves reset, from a 2-bit preset code. One preset code instead clears the offsets and enables loading them afterwards, either as a whole word or one bit at a time.

A flag asserts as soon as its own side's access crosses the threshold. It deasserts only after the other side's pointer has passed through the synchronizer, so it never reports free space or data that the local side cannot yet see. The fill level counts the words held in FIFO memory only. A word that has moved on into the FIFO's output register has already advanced the read pointer and is not counted.

Top module: `fifo_level_flags`

## Requirements
- R1: While rst_ni is low, both offsets are zero. On the first write-clock rising edge after rst_ni goes high, preset_sel_i is sampled and fixes the mode until the next reset. Code 0 sets both offsets to 8, code 1 sets both to 16, code 2 sets both to 64. Code 3 leaves both at 0 and enables programming.
- R2: With fill = write pointer minus read pointer (memory words only) and X the near-empty offset, ae_n_o is low when fill <= X and high when fill >= X+1.
- R3: When the write pointer changes after a read-clock rising edge, ae_n_o is still low after the first following read-clock rising edge and goes high on the second. A change that comes after an edge counts from the next edge.
- R4: When a read lowers fill to X or below, ae_n_o goes low as soon as rd_ptr_gray_i advances, with no synchronizer delay.
- R5: With Y the near-full offset and DEPTH = 2^ADDR_W, af_n_o is low when fill >= DEPTH-Y and high when fill <= DEPTH-Y-1.
- R6: After a read lowers fill to DEPTH-Y-1, af_n_o stays low after the first following write-clock rising edge and goes high on the second.
- R7: When a write raises fill to DEPTH-Y, af_n_o goes low as soon as wr_ptr_gray_i advances, with no synchronizer delay.
- R8: In programming mode, prog_load_i high at a write-clock edge loads prog_data_i into the near-empty offset (prog_tgt_i = 0) or the near-full offset (prog_tgt_i = 1).
- R9: In programming mode, prog_shift_i high at a write-clock edge, without prog_load_i, shifts prog_sdi_i into bit 0 of the near-empty offset. The near-empty MSB moves into bit 0 of the near-full offset, and the near-full MSB is dropped. To load an 18-bit word {Y, X}, send it MSB first. prog_load_i wins when both are high.
- R10: In preset modes 0 to 2, prog_load_i and prog_shift_i have no effect on either offset.
- R11: Both pointers are Gray-coded, ADDR_W+1 bits wide, and driven from registers in their own clock domain. Each crosses to the other domain through SYNC_STAGES (default 2) flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| preset_sel_i | input | 2 | Preset/mode code, sampled after reset |
| prog_load_i | input | 1 | Parallel offset load strobe (write clock) |
| prog_tgt_i | input | 1 | Parallel load target: 0 near-empty, 1 near-full |
| prog_data_i | input | ADDR_W | Parallel offset value |
| prog_shift_i | input | 1 | Serial shift strobe (write clock) |
| prog_sdi_i | input | 1 | Serial data bit |
| wr_ptr_gray_i | input | ADDR_W+1 | Gray write pointer, write-clock domain |
| rd_ptr_gray_i | input | ADDR_W+1 | Gray read pointer, read-clock domain |
| ae_n_o | output | 1 | Near-empty flag, active low, read domain |
| af_n_o | output | 1 | Near-full flag, active low, write domain |

## Verification
The bench builds the block with its defaults: ADDR_W = 9, giving 512 words, and SYNC_STAGES = 2. This puts the near-full thresholds at 504, 509 and 502 words, within a few hundred writes, so every preset and both programming paths are checked at their exact crossing points. The two clocks use periods of 4 ns and 6 ns with phases that never coincide with pointer updates. This lets the two-edge release be sampled edge by edge against the one-edge-early value.

// File: rtl/fifo_flags_pkg.sv
`timescale 1ns/1ps
package fifo_flags_pkg;

  typedef enum logic [1:0] {
    PRESET_8    = 2'd0,
    PRESET_16   = 2'd1,
    PRESET_64   = 2'd2,
    PRESET_PROG = 2'd3
  } preset_e;

  function automatic int unsigned preset_value(preset_e sel);
    case (sel)
      PRESET_8:  return 8;
      PRESET_16: return 16;
      PRESET_64: return 64;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/ptr_sync.sv
`timescale 1ns/1ps
module ptr_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/offset_regs.sv
`timescale 1ns/1ps
module offset_regs
  import fifo_flags_pkg::*;
#(
  parameter int OFS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       preset_sel_i,
  input  logic             prog_load_i,
  input  logic             prog_tgt_i,
  input  logic [OFS_W-1:0] prog_data_i,
  input  logic             prog_shift_i,
  input  logic             prog_sdi_i,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);

  logic             pend_q;
  logic             prog_en_q;
  logic [OFS_W-1:0] ae_q, af_q;
  preset_e          sel;

  assign sel = preset_e'(preset_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b1;
      prog_en_q <= 1'b0;
      ae_q      <= '0;
      af_q      <= '0;
    end else if (pend_q) begin
      pend_q    <= 1'b0;
      prog_en_q <= (sel == PRESET_PROG);
      ae_q      <= OFS_W'(preset_value(sel));
      af_q      <= OFS_W'(preset_value(sel));
    end else if (prog_en_q) begin
      if (prog_load_i) begin
        if (prog_tgt_i) af_q <= prog_data_i;
        else            ae_q <= prog_data_i;
      end else if (prog_shift_i) begin
        // serial chain: sdi -> ae[0] .. ae[msb] -> af[0] .. af[msb]
        {af_q, ae_q} <= {af_q[OFS_W-2:0], ae_q, prog_sdi_i};
      end
    end
  end

  assign ae_ofs_o = ae_q;
  assign af_ofs_o = af_q;

  AST_PEND_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q); // R1
  AST_PRESET_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !prog_en_q) |=> ($stable(ae_ofs_o) && $stable(af_ofs_o))); // R10
  AST_PAR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_q && prog_load_i && !prog_tgt_i) |=> (ae_ofs_o == $past(prog_data_i))); // R8
  AST_SER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_q && prog_shift_i && !prog_load_i) |=>
      (ae_ofs_o[0] == $past(prog_sdi_i) && af_ofs_o[0] == $past(ae_ofs_o[OFS_W-1]))); // R9

endmodule

// File: rtl/level_flag.sv
`timescale 1ns/1ps
module level_flag #(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter bit FULL_SIDE   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W:0]   local_gray_i,
  input  logic [ADDR_W:0]   remote_gray_i,
  input  logic [ADDR_W-1:0] ofs_i,
  output logic              flag_no
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] sync_gray;
  logic [PTR_W-1:0] local_bin, remote_bin, fill;

  ptr_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_ptr_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (remote_gray_i),
    .q_o    (sync_gray)
  );

  assign local_bin  = gray2bin(local_gray_i);
  assign remote_bin = gray2bin(sync_gray);

  generate
    if (FULL_SIDE) begin : g_full
      logic [PTR_W:0] reach;
      assign fill    = local_bin - remote_bin;
      assign reach   = {1'b0, fill} + (PTR_W+1)'(ofs_i);
      assign flag_no = (reach < (PTR_W+1)'(DEPTH));
    end else begin : g_empty
      assign fill    = remote_bin - local_bin;
      assign flag_no = (fill > PTR_W'(ofs_i));
    end
  endgenerate

  // flag can only release once the other side's pointer (or the offset) moved
  AST_RELEASE_NEEDS_REMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_no) |-> (!$stable(sync_gray) || !$stable(ofs_i))); // R3, R6
  AST_FILL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= PTR_W'(DEPTH)); // R2

endmodule

// File: rtl/fifo_level_flags.sv
`timescale 1ns/1ps
module fifo_level_flags #(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [1:0]        preset_sel_i,
  input  logic              prog_load_i,
  input  logic              prog_tgt_i,
  input  logic [ADDR_W-1:0] prog_data_i,
  input  logic              prog_shift_i,
  input  logic              prog_sdi_i,
  input  logic [ADDR_W:0]   wr_ptr_gray_i,
  input  logic [ADDR_W:0]   rd_ptr_gray_i,
  output logic              ae_n_o,
  output logic              af_n_o
);

  logic [ADDR_W-1:0] ae_ofs, af_ofs;

  // offsets live in the write domain; read side treats them as quasi-static
  offset_regs #(.OFS_W(ADDR_W)) i_offset_regs (
    .clk_i        (wclk_i),
    .rst_ni       (rst_ni),
    .preset_sel_i (preset_sel_i),
    .prog_load_i  (prog_load_i),
    .prog_tgt_i   (prog_tgt_i),
    .prog_data_i  (prog_data_i),
    .prog_shift_i (prog_shift_i),
    .prog_sdi_i   (prog_sdi_i),
    .ae_ofs_o     (ae_ofs),
    .af_ofs_o     (af_ofs)
  );

  level_flag #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .FULL_SIDE(1'b0)) i_empty_flag (
    .clk_i         (rclk_i),
    .rst_ni        (rst_ni),
    .local_gray_i  (rd_ptr_gray_i),
    .remote_gray_i (wr_ptr_gray_i),
    .ofs_i         (ae_ofs),
    .flag_no       (ae_n_o)
  );

  level_flag #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .FULL_SIDE(1'b1)) i_full_flag (
    .clk_i         (wclk_i),
    .rst_ni        (rst_ni),
    .local_gray_i  (wr_ptr_gray_i),
    .remote_gray_i (rd_ptr_gray_i),
    .ofs_i         (af_ofs),
    .flag_no       (af_n_o)
  );

endmodule

// File: tb/test_fifo_level_flags.sv
`timescale 1ns/1ps
module test_fifo_level_flags;

  localparam int ADDR_W = 9;
  localparam int PTR_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic [1:0]        preset_sel = 2'd0;
  logic              prog_load = 1'b0, prog_tgt = 1'b0, prog_shift = 1'b0, prog_sdi = 1'b0;
  logic [ADDR_W-1:0] prog_data = '0;
  logic [PTR_W-1:0]  wr_gray = '0, rd_gray = '0;
  logic              ae_n, af_n;

  int wcount = 0, rcount = 0, ofs_x = 8, ofs_y = 8;
  int checks = 0, errors = 0;

  always #2 wclk = ~wclk;  // 250 MHz
  initial begin #1; forever #3 rclk = ~rclk; end  // read edges at even ns, never at pointer updates

  fifo_level_flags #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_fifo_level_flags (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .preset_sel_i(preset_sel),
    .prog_load_i(prog_load), .prog_tgt_i(prog_tgt), .prog_data_i(prog_data),
    .prog_shift_i(prog_shift), .prog_sdi_i(prog_sdi),
    .wr_ptr_gray_i(wr_gray), .rd_ptr_gray_i(rd_gray),
    .ae_n_o(ae_n), .af_n_o(af_n)
  );

  // R11 pointer encoding: binary count to Gray
  function automatic logic [PTR_W-1:0] to_gray(input int v);
    logic [PTR_W-1:0] b;
    b = v[PTR_W-1:0];
    return b ^ (b >> 1);
  endfunction

  function automatic logic exp_ae();
    return (wcount - rcount) > ofs_x;
  endfunction

  function automatic logic exp_af();
    return (wcount - rcount) < (DEPTH - ofs_y);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (fill %0d)", req, act, exp, wcount - rcount);
    end
  endtask

  task automatic wr(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge wclk); #1;
      wcount++;
      wr_gray = to_gray(wcount);
    end
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge rclk); #1;
      rcount++;
      rd_gray = to_gray(rcount);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge rclk);
    repeat (3) @(posedge wclk);
    #0.5;
  endtask

  task automatic do_reset(input logic [1:0] sel, input int x, input int y);
    @(negedge wclk);
    rst_ni = 1'b0;
    wcount = 0; rcount = 0;
    wr_gray = '0; rd_gray = '0;
    prog_load = 1'b0; prog_shift = 1'b0;
    preset_sel = sel;
    ofs_x = x; ofs_y = y;
    repeat (3) @(negedge wclk);
    rst_ni = 1'b1;
    settle();
  endtask

  task automatic par_load(input logic tgt, input logic [ADDR_W-1:0] val);
    @(negedge wclk);
    prog_load = 1'b1; prog_tgt = tgt; prog_data = val;
    @(negedge wclk);
    prog_load = 1'b0;
  endtask

  task automatic ser_load(input logic [2*ADDR_W-1:0] bits);
    for (int i = 2*ADDR_W-1; i >= 0; i--) begin
      @(negedge wclk);
      prog_shift = 1'b1; prog_sdi = bits[i];
    end
    @(negedge wclk);
    prog_shift = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'd0, 8, 8);
    chk("R1 reset ae", ae_n, 1'b0);
    chk("R1 reset af", af_n, 1'b1);
  endtask

  task automatic t_ae_release();
    wr(8); settle();
    chk("R2 ae at X", ae_n, exp_ae());
    wr(1);
    @(posedge rclk); #1;
    chk("R3 ae after first edge", ae_n, 1'b0);
    @(posedge rclk); #1;
    chk("R3/R11 ae after second edge", ae_n, 1'b1);
  endtask

  task automatic t_ae_read();
    rd(1); #0.5;
    chk("R4 ae on read", ae_n, 1'b0);
    chk("R2 ae model", ae_n, exp_ae());
  endtask

  task automatic t_af();
    wr(495); settle();
    chk("R5 af at DEPTH-Y-1", af_n, 1'b1);
    wr(1); #0.5;
    chk("R7 af on write", af_n, 1'b0);
    chk("R5 af model", af_n, exp_af());
    rd(1); #0.5;
    chk("R6 af right after read", af_n, 1'b0);
    @(posedge wclk); #0.5;
    chk("R6 af after first edge", af_n, 1'b0);
    @(posedge wclk); #0.5;
    chk("R6 af after second edge", af_n, 1'b1);
  endtask

  task automatic t_presets();
    do_reset(2'd1, 16, 16);
    wr(16); settle();
    chk("R1 preset16 ae at X", ae_n, 1'b0);
    wr(1); settle();
    chk("R1 preset16 ae at X+1", ae_n, 1'b1);
    do_reset(2'd2, 64, 64);
    wr(64); settle();
    chk("R1 preset64 ae at X", ae_n, 1'b0);
    wr(1); settle();
    chk("R1 preset64 ae at X+1", ae_n, 1'b1);
    chk("R1 preset64 af", af_n, exp_af());
  endtask

  task automatic t_prog_parallel();
    do_reset(2'd3, 0, 0);
    chk("R1 prog mode ae", ae_n, 1'b0);
    chk("R1 prog mode af", af_n, 1'b1);
    par_load(1'b0, 9'd5);
    par_load(1'b1, 9'd3);
    ofs_x = 5; ofs_y = 3;
    wr(5); settle();
    chk("R8 ae at 5", ae_n, exp_ae());
    wr(1); settle();
    chk("R8 ae at 6", ae_n, exp_ae());
    wr(502); settle();
    chk("R8 af at 508", af_n, exp_af());
    wr(1); #0.5;
    chk("R8 af at 509", af_n, 1'b0);
  endtask

  task automatic t_prog_serial();
    do_reset(2'd3, 0, 0);
    ser_load({9'd10, 9'd2});
    ofs_x = 2; ofs_y = 10;
    wr(2); settle();
    chk("R9 ae at 2", ae_n, 1'b0);
    wr(1); settle();
    chk("R9 ae at 3", ae_n, 1'b1);
    wr(498); settle();
    chk("R9 af at 501", af_n, 1'b1);
    wr(1); #0.5;
    chk("R9 af at 502", af_n, 1'b0);
  endtask

  task automatic t_preset_ignores();
    do_reset(2'd0, 8, 8);
    par_load(1'b0, 9'd0);
    par_load(1'b1, 9'd500);
    ser_load('1);
    wr(1); settle();
    chk("R10 ae keeps preset", ae_n, 1'b0);
    chk("R10 af keeps preset", af_n, 1'b1);
    wr(8); settle();
    chk("R10 ae at 9 words", ae_n, exp_ae());
  endtask

  initial begin
    t_reset();
    t_ae_release();
    t_ae_read();
    t_af();
    t_presets();
    t_prog_parallel();
    t_prog_serial();
    t_preset_ignores();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule